// File: doc/BRIEF.md
# Bernoulli Compressed-Sensing Accumulator Bank

This block turns a window of N signed 10-bit samples into M measurement sums. Each sum is the inner product of the window with one row of a pseudo-random 0/1 matrix. The matrix is never stored. Each accepted sample consumes one column of it, and that column comes from two free-running shift-register generators. Each 1 in the column adds the sample into that row's accumulator. Each 0 leaves the accumulator alone, so the datapath needs no multiplier.

Samples arrive on a valid/ready input that also carries a per-sample activity flag. The window length N and the row count M are sampled when the first sample of a window is accepted. When the last sample of the window has been taken, the block closes the input. It then hands out the M sums in row order on a valid/ready output. Every word carries the window's compression factor, so the receiver knows how to rebuild the signal. A window in which no sample was flagged as active produces no output at all. A reseed pulse puts both generators back to their seeds, which lets the receiver regenerate the same matrix.

Top module: `cs_accum_bank`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. The row generator holds 8'hA5 and the 16-bit generator holds 16'hACE1.
- R2: The matrix bit for row r is A[r] XOR B[(2r+1) mod 16]. A shifts left, and its new bit 0 is A[7]^A[5]^A[4]^A[3]. B shifts left, and its new bit 0 is B[15]^B[13]^B[12]^B[10]. Each accepted sample uses the current state, and both generators then step once.
- R3: Row r's output equals the sum of the window's samples whose matrix bit for row r was 1. A 0 bit leaves that row unchanged.
- R4: Every addition saturates at +16383 and at -16384. The accumulator is 15 bits wide.
- R5: The cfg_n and cfg_m values present on the cycle the first sample of a window is accepted govern the whole window. Changes later in the window are ignored.
- R6: A cfg_n of 0 or above 64 means N = 64. A cfg_m of 0 or above 8 means M = 8.
- R7: After the last sample, in_ready stays 0 and M words are presented for rows 0 to M-1 in order. Each word is held stable while out_ready is 0. After the final word is taken, in_ready returns to 1. in_ready and out_valid are never 1 together.
- R8: Every output word carries out_cf = floor(N/M) of its window.
- R9: A window in which in_act was 0 for every sample produces no output word, and in_ready stays 1.
- R10: A reseed pulse reloads both generators with their seeds, so the next window repeats the same matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reseed | input | 1 | Reload both matrix generators with their seeds |
| cfg_n | input | 7 | Window length request |
| cfg_m | input | 4 | Row count request |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted this cycle when in_valid is high |
| in_data | input | 10 | Signed sample |
| in_act | input | 1 | Activity flag for this sample |
| out_valid | output | 1 | Measurement word present |
| out_ready | input | 1 | Receiver takes the word |
| out_data | output | 15 | Signed measurement sum |
| out_row | output | 3 | Row index of the word |
| out_cf | output | 7 | Compression factor of the window |

## Verification
The bound checker watches the output ordering on every cycle. It confirms that the input and output handshakes never overlap. It confirms that a stalled word and its tag stay frozen, that a drain starts at row 0 and advances one row per accepted word without passing M, and that the factor tag is constant across a drain. The numeric sums cannot be checked cycle by cycle without the matrix, so only the bench's scenarios show them. Those scenarios cover the matrix sequence, saturation with extreme inputs, configuration clamping, late configuration changes, quiet windows and reseeding, all against a model the bench keeps on its own.

// File: rtl/cs_accum_bank.sv
module cs_accum_bank #(
  parameter int DW = 10,
  parameter int NMAX = 64,
  parameter int MMAX = 8,
  parameter logic [MMAX-1:0] A_TAPS = 8'hB8,
  parameter logic [MMAX-1:0] A_SEED = 8'hA5,
  parameter logic [15:0] B_TAPS = 16'hB400,
  parameter logic [15:0] B_SEED = 16'hACE1,
  localparam int ACCW = DW + $clog2(NMAX) - 1,
  localparam int NW = $clog2(NMAX + 1),
  localparam int MW = $clog2(MMAX + 1),
  localparam int RW = $clog2(MMAX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reseed,
  input  logic [NW-1:0]          cfg_n,
  input  logic [MW-1:0]          cfg_m,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [DW-1:0]   in_data,
  input  logic                   in_act,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic signed [ACCW-1:0] out_data,
  output logic [RW-1:0]          out_row,
  output logic [NW-1:0]          out_cf
);

  localparam logic signed [ACCW-1:0] SMAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] SMIN = {1'b1, {(ACCW-1){1'b0}}};

  logic [MMAX-1:0] a_q, col;
  logic [15:0]     b_q;
  logic            draining, act_q;
  logic [NW-1:0]   cnt, n_q, cf_q, n_in, eff_n;
  logic [MW-1:0]   m_q, m_in, eff_m;
  logic [RW-1:0]   idx;
  logic signed [ACCW-1:0] acc [MMAX];

  function automatic logic signed [ACCW-1:0] sat_add(input logic signed [ACCW-1:0] a,
                                                     input logic signed [DW-1:0] x);
    logic signed [ACCW:0] s;
    s = {a[ACCW-1], a} + {{(ACCW+1-DW){x[DW-1]}}, x};
    if (s[ACCW] != s[ACCW-1]) return s[ACCW] ? SMIN : SMAX;
    return s[ACCW-1:0];
  endfunction

  assign n_in = (cfg_n == '0 || int'(cfg_n) > NMAX) ? NW'(NMAX) : cfg_n;
  assign m_in = (cfg_m == '0 || int'(cfg_m) > MMAX) ? MW'(MMAX) : cfg_m;

  wire first   = (cnt == '0);
  assign eff_n = first ? n_in : n_q;
  assign eff_m = first ? m_in : m_q;

  wire accept  = in_valid && !draining;
  wire last_in = accept && (NW'(cnt + 1'b1) == eff_n);
  wire any_act = in_act || (act_q && !first);

  assign in_ready  = !draining;
  assign out_valid = draining;
  assign out_row   = idx;
  assign out_data  = acc[idx];
  assign out_cf    = cf_q;

  genvar r;
  generate
    for (r = 0; r < MMAX; r++) begin : g_row
      logic signed [ACCW-1:0] q;
      wire signed [ACCW-1:0] base = first ? '0 : q;
      assign col[r] = a_q[r] ^ b_q[(2*r+1) % 16];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else if (accept && MW'(r) < eff_m) q <= col[r] ? sat_add(base, in_data) : base;
      assign acc[r] = q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= A_SEED;
      b_q <= B_SEED;
    end else if (reseed) begin
      a_q <= A_SEED;
      b_q <= B_SEED;
    end else if (accept) begin
      a_q <= {a_q[MMAX-2:0], ^(a_q & A_TAPS)};
      b_q <= {b_q[14:0], ^(b_q & B_TAPS)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      draining <= 1'b0;
      act_q    <= 1'b0;
      cnt      <= '0;
      n_q      <= NW'(NMAX);
      m_q      <= MW'(MMAX);
      cf_q     <= '0;
      idx      <= '0;
    end else begin
      if (accept) begin
        if (first) begin
          n_q  <= n_in;
          m_q  <= m_in;
          cf_q <= n_in / NW'(m_in);
        end
        act_q <= any_act;
        if (last_in) begin
          cnt <= '0;
          idx <= '0;
          draining <= any_act;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (draining && out_ready) begin
        if (MW'(idx) == m_q - MW'(1)) draining <= 1'b0;
        else idx <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cs_accum_bank_chk.sv
module cs_accum_bank_chk #(
  parameter int ACCW = 15,
  parameter int NW = 7,
  parameter int MW = 4,
  parameter int RW = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic signed [ACCW-1:0] out_data,
  input logic [RW-1:0]          out_row,
  input logic [NW-1:0]          out_cf,
  input logic [MW-1:0]          m_q
);

  // R7
  handshake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_row) && $stable(out_cf));

  // R7
  drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_row == '0);

  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || out_row == RW'($past(out_row) + 1'b1));

  // R7
  row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_row) < int'(m_q));

  // R8
  cf_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> $stable(out_cf));

endmodule

bind cs_accum_bank cs_accum_bank_chk #(.ACCW(ACCW), .NW(NW), .MW(MW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_row(out_row),
  .out_cf(out_cf), .m_q(m_q)
);

// File: tb/tb_cs_accum_bank.sv
module tb_cs_accum_bank;
  logic clk = 1'b0, rst_n = 1'b0, reseed = 1'b0;
  logic [6:0] cfg_n = 7'd0;
  logic [3:0] cfg_m = 4'd0;
  logic in_valid = 1'b0, in_act = 1'b0, out_ready = 1'b0;
  logic signed [9:0] in_data = '0;
  logic in_ready, out_valid;
  logic signed [14:0] out_data;
  logic [2:0] out_row;
  logic [6:0] out_cf;

  always #2 clk = ~clk;

  cs_accum_bank dut (.*);

  int checks = 0, fails = 0;
  logic [7:0] ma = 8'hA5;
  logic [15:0] mb = 16'hACE1;
  int exp_acc [8];
  int first_run [8];

  // {n, m, kind}; kind 0 ramp, 1 max, 2 min, 3 alternating, 4 quiet
  localparam logic [13:0] VEC [8] = '{
    {7'd20, 4'd5, 3'd0}, {7'd64, 4'd8, 3'd1}, {7'd64, 4'd8, 3'd2}, {7'd12, 4'd3, 3'd3},
    {7'd10, 4'd4, 3'd4}, {7'd0, 4'd0, 3'd0}, {7'd100, 4'd12, 3'd3}, {7'd7, 4'd1, 3'd3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sval(input int k, input int j);
    case (k)
      1: return 511;
      2: return -512;
      3: return (j % 2) ? 300 : -200;
      default: return ((j * 37 + 5) % 1024) - 512;
    endcase
  endfunction

  task automatic model_step(input int v, input int m);
    for (int r = 0; r < m; r++)
      if (ma[r] ^ mb[(2*r+1) % 16]) begin
        exp_acc[r] += v;
        if (exp_acc[r] > 16383) exp_acc[r] = 16383;
        if (exp_acc[r] < -16384) exp_acc[r] = -16384;
      end
    ma = {ma[6:0], ma[7] ^ ma[5] ^ ma[4] ^ ma[3]};
    mb = {mb[14:0], mb[15] ^ mb[13] ^ mb[12] ^ mb[10]};
  endtask

  task automatic do_reseed();
    @(negedge clk); reseed = 1'b1;
    @(negedge clk); reseed = 1'b0;
    ma = 8'hA5; mb = 16'hACE1;
  endtask

  task automatic run_window(input int nr, input int mr, input int k, input bit stall, input bit chg);
    int n, m;
    bit act;
    n = (nr == 0 || nr > 64) ? 64 : nr;
    m = (mr == 0 || mr > 8) ? 8 : mr;
    act = (k != 4);
    for (int r = 0; r < 8; r++) exp_acc[r] = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (j == 0) begin cfg_n = 7'(nr); cfg_m = 4'(mr); end
      if (j == 1 && chg) begin cfg_n = 7'd40; cfg_m = 4'd2; end
      in_valid = 1'b1;
      in_data = 10'(sval(k, j));
      in_act = act && (j == n / 2);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      model_step(sval(k, j), m);
    end
    @(negedge clk);
    in_valid = 1'b0; in_act = 1'b0;
    if (!act) begin
      for (int c = 0; c < 3; c++) begin
        chk(!out_valid && in_ready, "R9 quiet window", int'(out_valid), 0);
        @(negedge clk);
      end
      return;
    end
    for (int r = 0; r < m; r++) begin
      if (r > 0) @(negedge clk);
      out_ready = 1'b0;
      if (stall && r == 1) begin
        for (int c = 0; c < 3; c++) begin
          @(negedge clk);
          chk(out_valid && !in_ready && out_row == 3'(r), "R7 stall hold", int'(out_row), r);
        end
      end
      chk(out_valid && !in_ready, "R7 drain valid", int'(out_valid), 1);
      chk(out_row == 3'(r), "R7 row order", int'(out_row), r);
      chk(int'(out_data) == exp_acc[r], "R3 R4 measurement", int'(out_data), exp_acc[r]);
      chk(int'(out_cf) == n / m, "R8 cf tag", int'(out_cf), n / m);
      out_ready = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R7 drain end", int'(in_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid, "R1 reset state", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1 after release", int'(in_ready), 1);
    // R2 R3 R4 R6 R9: table walk
    foreach (VEC[i])
      run_window(int'(VEC[i][13:7]), int'(VEC[i][6:3]), int'(VEC[i][2:0]), 1'b0, 1'b0);
    // R7 back-pressure
    run_window(16, 4, 0, 1'b1, 1'b0);
    // R5 late configuration change ignored
    run_window(16, 4, 3, 1'b0, 1'b1);
    // R10 reseed repeats the matrix
    do_reseed();
    run_window(16, 4, 0, 1'b0, 1'b0);
    for (int r = 0; r < 4; r++) first_run[r] = exp_acc[r];
    run_window(9, 3, 1, 1'b0, 1'b0);
    do_reseed();
    run_window(16, 4, 0, 1'b0, 1'b0);
    for (int r = 0; r < 4; r++)
      chk(exp_acc[r] == first_run[r], "R10 same matrix", exp_acc[r], first_run[r]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule